// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host request port and a four-bank, 32-bit single-data-rate SDRAM. After reset it waits a stabilisation time and then brings the memory up: precharge of every bank, two auto refreshes and a mode-register load. From then on it serves one host access at a time with a closed-page policy. Each access opens the row, issues one read or write column command with a burst length of one, and closes the row with a single-bank precharge.

All spacing between commands comes from nanosecond minimums. The parameter `CLK_PS` holds the clock period, and each minimum is rounded up to whole clocks. A free-running interval timer raises a refresh request. That request is served as soon as the sequencer is idle, ahead of any waiting host request, but it never interrupts an access already in flight.

Read data returns on the DQ input a programmable latency of 2 or 3 clocks after the read. The block captures it into a registered read port. The bidirectional DQ bus is split into separate in, out and output-enable signals.

Top module: `sdr_cmd_seq`

## Requirements
- R1: Commands on {cs_n, ras_n, cas_n, we_n} use this encoding: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111. While reset is held, the command is no-op, CKE is low and req_ready is low. CKE is high from the first clock edge after reset.
- R2: Power-up runs as follows, counting edges after reset release with the first edge numbered 1. At edge INIT_CYC, a precharge with A10=1 (all banks) is issued. T_RP clocks later comes a refresh, T_RFC clocks after that a second refresh, and T_RFC clocks after that the mode load. req_ready stays low until T_MRD clocks after the mode load, and no other command falls in that gap.
- R3: The mode load drives BA=0 and A = CAS latency in A6:A4, with all other bits zero (burst length 1, sequential, burst write). This gives 12'h030 for latency 3 and 12'h020 for latency 2.
- R4: req_ready is high only when the sequencer is idle, all spacing has expired and no refresh is pending. A request accepted at an edge puts an activate on the pins at that same edge. The activate drives BA = req_addr[10:9] and A = req_addr[22:11].
- R5: The read or write command follows the activate after T_RCD clocks. It drives the same BA, A8:A0 = req_addr[8:0] and A11:A9 = 0, so A10=0 and there is no auto-precharge.
- R6: A precharge with A10=0 to the same bank follows the column command after max(max(T_RAS, T_RC−T_RP)−T_RCD, T_WR) clocks. The next command follows the precharge after at least T_RP clocks, and two back-to-back accesses start T_RC or more clocks apart. At a 5 ns clock these values are 4/9/4 and 13.
- R7: A refresh request is raised every REF_CYC clocks from reset release (at edge k·REF_CYC). When idle, a refresh is issued at the next edge and takes priority over a waiting host request. A refresh that becomes due during an access is issued at the first idle edge after the access. Nothing else follows a refresh for T_RFC clocks.
- R8: dq_oe is high, dq_out carries the write data and dqm = ~req_be (bit i set masks byte i) only in the clock of the write command. In every other clock, dq_oe is low and dqm is 0.
- R9: rd_valid pulses for one clock at edge E+CL+1, where E is the edge that put a read on the pins. rd_data then holds the dq_in value present just before that edge, and keeps it until the next read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Row [22:11], bank [10:9], column [8:0] |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Captured read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Address bus |
| sd_dqm | output | 4 | Byte mask |
| sd_dq_in | input | 32 | Data from the memory |
| sd_dq_out | output | 32 | Data to the memory |
| sd_dq_oe | output | 1 | Drive enable for DQ |

## Verification
A wrong state or wait count in the sequencer shows on the command pins within one access. A command lands a clock early or late against the activate, or a precharge crowds the next activate. Because the bench logs every non-idle command with its edge number, such a fault shows up at the first access. A stuck or mistimed refresh timer only shows up at the first interval boundary, a few thousand clocks in. A wrong read latency stage shows as rd_valid one edge off, or as stale data, on the first read.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP, ST_REF1, ST_REF2, ST_MRS, ST_IDLE, ST_RW, ST_PRE
    } seq_state_e;

    // round a picosecond minimum up to whole clocks, at least one
    function automatic int ps_to_clk(input int ps, input int clk_ps);
        int n;
        n = (ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int unsigned PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ack) t_d.pend = 1'b0;
        if (t_q.cnt == '0) begin
            t_d.cnt  = CW'(PERIOD - 1);
            t_d.pend = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.cnt  <= CW'(PERIOD - 1);
            t_q.pend <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pending = t_q.pend;

    // R7: the sequencer acknowledges only a request that is raised
    assert_ack_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> t_q.pend);

    // R7: a raised request is held until it is served
    assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.pend && !ack) |=> t_q.pend);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [CAS_LAT-1:0] pipe;
        logic               vld;
        logic [DATA_W-1:0]  data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.pipe = {c_q.pipe[CAS_LAT-2:0], issue};
        c_d.vld  = c_q.pipe[CAS_LAT-1];
        if (c_q.pipe[CAS_LAT-1]) c_d.data = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_valid = c_q.vld;
    assign rd_data  = c_q.data;

    // R9: reads are spaced far enough apart that at most one is in flight
    assert_one_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(c_q.pipe) <= 1);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int CLK_PS  = 5000,
    parameter int CAS_LAT = 3,
    parameter int INIT_PS = 200_000_000,
    parameter int REF_PS  = 15_600_000,
    parameter int ROW_W   = 12,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    input  logic [DATA_W/8-1:0]             req_be,
    output logic                            rd_valid,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_a,
    output logic [DATA_W/8-1:0]             sd_dqm,
    input  logic [DATA_W-1:0]               sd_dq_in,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe
);
    localparam int ADDR_W    = ROW_W + BANK_W + COL_W;
    localparam int BE_W      = DATA_W / 8;
    localparam int T_RCD     = ps_to_clk(20000, CLK_PS);
    localparam int T_RP      = ps_to_clk(20000, CLK_PS);
    localparam int T_RAS     = ps_to_clk(45000, CLK_PS);
    localparam int T_RC      = ps_to_clk(65000, CLK_PS);
    localparam int T_RFC     = ps_to_clk(65000, CLK_PS);
    localparam int T_MRD     = 2;
    localparam int T_WR      = 2;
    localparam int T_RAS_EFF = max2(T_RAS, T_RC - T_RP);
    localparam int W_PRE     = max2(T_RAS_EFF - T_RCD, T_WR);
    localparam int INIT_CYC  = ps_to_clk(INIT_PS, CLK_PS);
    localparam int REF_CYC   = ps_to_clk(REF_PS, CLK_PS);
    localparam int MAX_D     = max2(INIT_CYC, max2(T_RFC, max2(W_PRE, max2(T_RP, T_RCD))));
    localparam int CNT_W     = $clog2(MAX_D + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        sdr_cmd_e          cmd;
        logic              cke;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic [BE_W-1:0]   dqm;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } seq_t;

    seq_t r_d, r_q;
    logic ref_pend, ref_ack;

    sdr_refresh_timer #(.PERIOD(REF_CYC)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        r_d.cke = 1'b1;
        r_d.oe  = 1'b0;
        r_d.dqm = '0;
        ref_ack = 1'b0;
        if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end else begin
            unique case (r_q.st)
                ST_PWRUP: begin
                    r_d.cmd   = CMD_PRE;
                    r_d.ba    = '0;
                    r_d.a     = '0;
                    r_d.a[10] = 1'b1;
                    r_d.cnt   = CNT_W'(T_RP - 1);
                    r_d.st    = ST_REF1;
                end
                ST_REF1, ST_REF2: begin
                    r_d.cmd = CMD_REF;
                    r_d.cnt = CNT_W'(T_RFC - 1);
                    r_d.st  = (r_q.st == ST_REF1) ? ST_REF2 : ST_MRS;
                end
                ST_MRS: begin
                    r_d.cmd = CMD_MRS;
                    r_d.ba  = '0;
                    r_d.a   = MODE_WORD;
                    r_d.cnt = CNT_W'(T_MRD - 1);
                    r_d.st  = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        r_d.cmd = CMD_REF;
                        r_d.cnt = CNT_W'(T_RFC - 1);
                        ref_ack = 1'b1;
                    end else if (req_valid) begin
                        r_d.cmd   = CMD_ACT;
                        r_d.ba    = req_addr[COL_W +: BANK_W];
                        r_d.a     = req_addr[ADDR_W-1 -: ROW_W];
                        r_d.addr  = req_addr;
                        r_d.wr    = req_write;
                        r_d.wdata = req_wdata;
                        r_d.be    = req_be;
                        r_d.cnt   = CNT_W'(T_RCD - 1);
                        r_d.st    = ST_RW;
                    end
                end
                ST_RW: begin
                    r_d.cmd              = r_q.wr ? CMD_WR : CMD_RD;
                    r_d.a                = '0;
                    r_d.a[COL_W-1:0]     = r_q.addr[COL_W-1:0];
                    if (r_q.wr) begin
                        r_d.oe   = 1'b1;
                        r_d.dout = r_q.wdata;
                        r_d.dqm  = ~r_q.be;
                    end
                    r_d.cnt = CNT_W'(W_PRE - 1);
                    r_d.st  = ST_PRE;
                end
                ST_PRE: begin
                    r_d.cmd = CMD_PRE;
                    r_d.a   = '0;
                    r_d.cnt = CNT_W'(T_RP - 1);
                    r_d.st  = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_PWRUP;
            r_q.cnt <= CNT_W'(INIT_CYC - 1);
            r_q.cmd <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .issue(r_q.cmd == CMD_RD),
        .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign req_ready = (r_q.st == ST_IDLE) && (r_q.cnt == '0) && !ref_pend;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = r_q.cmd;
    assign sd_cke    = r_q.cke;
    assign sd_ba     = r_q.ba;
    assign sd_a      = r_q.a;
    assign sd_dqm    = r_q.dqm;
    assign sd_dq_out = r_q.dout;
    assign sd_dq_oe  = r_q.oe;

    // R2: the clock after a mode load carries no command
    assert_mrs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_MRS) |=> (r_q.cmd == CMD_NOP));

    // R4: an accepted request becomes an activate at the accepting edge
    assert_accept_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (r_q.cmd == CMD_ACT));

    // R5: the clock after an activate is idle whenever T_RCD exceeds one
    assert_act_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_RCD > 1) && r_q.cmd == CMD_ACT) |=> (r_q.cmd == CMD_NOP));

    // R8: data drive and masking only accompany a write
    assert_oe_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != CMD_WR) |-> (!sd_dq_oe && sd_dqm == '0));

    // R1: refresh is only issued with CKE high
    assert_ref_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_REF) |-> sd_cke);

endmodule

// File: tb/sdr_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdr_cmd_seq_tb;
    localparam int CL = 3;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [22:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic rd_valid; logic [31:0] rd_data;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba; logic [11:0] sd_a; logic [3:0] sd_dqm;
    logic [31:0] sd_dq_in = '0, sd_dq_out;

    always #2.5 clk = ~clk;

    sdr_cmd_seq #(.CLK_PS(5000), .CAS_LAT(CL), .INIT_PS(1_000_000), .REF_PS(15_600_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe)
    );

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0, bad_oe = 0;
    logic [3:0]  l_cmd [0:255]; int l_cyc [0:255]; logic [1:0] l_ba [0:255];
    logic [11:0] l_a [0:255]; logic l_oe [0:255]; logic [31:0] l_dout [0:255];
    logic [3:0] l_dqm [0:255]; int n_log = 0;
    int rv_cyc [0:63]; logic [31:0] rv_data [0:63]; int n_rv = 0;
    logic [31:0] mem [int]; logic [11:0] open_row [0:3]; logic [31:0] rp [0:3];

    function automatic int mkey(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
        return int'({9'd0, b, r, c});
    endfunction

    // memory model and command log, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c; logic [31:0] w; int k;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            for (int i = 3; i > 0; i--) rp[i] = rp[i-1];
            rp[0] = 32'hDEAD_BEEF;
            if (c != C_NOP && n_log < 256) begin
                l_cmd[n_log] = c; l_cyc[n_log] = cyc; l_ba[n_log] = sd_ba; l_a[n_log] = sd_a;
                l_oe[n_log] = sd_dq_oe; l_dout[n_log] = sd_dq_out; l_dqm[n_log] = sd_dqm;
                n_log++;
            end
            if (c == C_ACT) open_row[sd_ba] = sd_a;
            if (c == C_WR || c == C_RD) begin
                k = mkey(sd_ba, open_row[sd_ba], sd_a[8:0]);
                w = mem.exists(k) ? mem[k] : 32'h0;
                if (c == C_WR) begin
                    for (int b = 0; b < 4; b++) if (!sd_dqm[b]) w[b*8 +: 8] = sd_dq_out[b*8 +: 8];
                    mem[k] = w;
                end else rp[0] = w;
            end
            sd_dq_in = rp[CL];
            if (c != C_WR && (sd_dq_oe || sd_dqm != 4'h0)) bad_oe++;
            if (rd_valid && n_rv < 64) begin rv_cyc[n_rv] = cyc; rv_data[n_rv] = rd_data; n_rv++; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int find_cmd(input logic [3:0] c, input int from);
        for (int i = 0; i < n_log; i++) if (l_cmd[i] == c && l_cyc[i] >= from) return i;
        return -1;
    endfunction

    task automatic expect_cmd(input logic [3:0] c, input int from, input int exp_cyc,
                              input string req, output int idx);
        idx = find_cmd(c, from);
        chk(idx >= 0 && l_cyc[idx] == exp_cyc, req, "command edge",
            (idx >= 0) ? l_cyc[idx] : -1, exp_cyc);
    endtask

    task automatic expect_rv(input int from, input int exp_cyc, input logic [31:0] exp_d);
        int i; i = -1;
        for (int j = n_rv - 1; j >= 0; j--) if (rv_cyc[j] >= from) i = j;
        chk(i >= 0 && rv_cyc[i] == exp_cyc, "R9", "rd_valid edge", (i >= 0) ? rv_cyc[i] : -1, exp_cyc);
        chk(i >= 0 && rv_data[i] == exp_d, "R9", "rd_data", (i >= 0) ? rv_data[i] : 0, exp_d);
    endtask

    // called at a negedge; returns the edge number at which the request is taken
    task automatic do_req(input bit w, input logic [22:0] ad, input logic [31:0] d,
                          input logic [3:0] be, output int acc);
        req_valid = 1'b1; req_write = w; req_addr = ad; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    localparam logic [22:0] A1 = {12'hABC, 2'd2, 9'h155};
    localparam logic [22:0] A2 = {12'h123, 2'd0, 9'h00F};
    localparam logic [22:0] A3 = {12'hFFF, 2'd3, 9'h1FF};

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(sd_cke == 1'b0 && req_ready == 1'b0, "R1", "reset cke/ready", {sd_cke, req_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cke == 1'b1, "R1", "cke after first edge", sd_cke, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "nop after reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    endtask

    task automatic t_powerup;
        wait_until(230);
        chk(req_ready == 1'b0, "R2", "ready after mode load", req_ready, 0);
        wait_until(231);
        chk(req_ready == 1'b1, "R2", "ready T_MRD after mode load", req_ready, 1);
        chk(n_log == 4, "R2", "init command count", n_log, 4);
        chk(l_cmd[0] == C_PRE && l_cyc[0] == 200 && l_a[0][10], "R2", "precharge-all edge", l_cyc[0], 200);
        chk(l_cmd[1] == C_REF && l_cyc[1] == 204, "R2", "first refresh edge", l_cyc[1], 204);
        chk(l_cmd[2] == C_REF && l_cyc[2] == 217, "R2", "second refresh edge", l_cyc[2], 217);
        chk(l_cmd[3] == C_MRS && l_cyc[3] == 230, "R2", "mode load edge", l_cyc[3], 230);
        chk(l_a[3] == 12'h030 && l_ba[3] == 2'd0, "R3", "mode word", {l_ba[3], l_a[3]}, 12'h030);
    endtask

    task automatic t_write_full;
        int acc, i;
        wait_until(240);
        do_req(1'b1, A1, 32'h1122_3344, 4'hF, acc);
        wait_until(acc + 20);
        expect_cmd(C_ACT, acc, acc, "R4", i);
        if (i >= 0) chk(l_ba[i] == 2'd2 && l_a[i] == 12'hABC, "R4", "activate bank/row", {l_ba[i], l_a[i]}, 14'h2ABC);
        expect_cmd(C_WR, acc, acc + 4, "R5", i);
        if (i >= 0) begin
            chk(l_a[i] == 12'h155 && l_ba[i] == 2'd2, "R5", "write column", l_a[i], 12'h155);
            chk(l_oe[i] && l_dout[i] == 32'h1122_3344 && l_dqm[i] == 4'h0, "R8", "write drive",
                l_dout[i], 32'h1122_3344);
        end
        expect_cmd(C_PRE, acc, acc + 9, "R6", i);
        if (i >= 0) chk(!l_a[i][10] && l_ba[i] == 2'd2, "R6", "single-bank precharge", {l_a[i][10], l_ba[i]}, 2);
    endtask

    task automatic t_read_back(input logic [31:0] exp_d);
        int acc, i;
        @(negedge clk);
        do_req(1'b0, A1, 32'h0, 4'h0, acc);
        wait_until(acc + 20);
        expect_cmd(C_RD, acc, acc + 4, "R5", i);
        if (i >= 0) chk(l_a[i] == 12'h155, "R5", "read column, no auto-precharge", l_a[i], 12'h155);
        expect_rv(acc, acc + 4 + CL + 1, exp_d);
    endtask

    task automatic t_mask;
        int acc, i;
        @(negedge clk);
        do_req(1'b1, A1, 32'hAABB_CCDD, 4'b0101, acc);
        wait_until(acc + 20);
        expect_cmd(C_WR, acc, acc + 4, "R8", i);
        if (i >= 0) chk(l_dqm[i] == 4'b1010, "R8", "write mask", l_dqm[i], 4'b1010);
    endtask

    task automatic t_back_to_back;
        int a1, a2, i;
        @(negedge clk);
        do_req(1'b1, A2, 32'h5555_0001, 4'hF, a1);
        do_req(1'b1, A3, 32'h5555_0002, 4'hF, a2);
        chk(a2 - a1 == 13, "R6", "activate-to-activate spacing", a2 - a1, 13);
        wait_until(a2 + 20);
        expect_cmd(C_PRE, a1, a1 + 9, "R6", i);
        expect_cmd(C_ACT, a1 + 1, a1 + 13, "R6", i);
        if (i >= 0) chk(l_ba[i] == 2'd3 && l_a[i] == 12'hFFF, "R4", "second activate", {l_ba[i], l_a[i]}, 14'h3FFF);
    endtask

    task automatic t_refresh_idle;
        int i;
        wait_until(3120);
        chk(req_ready == 1'b0, "R7", "ready while refresh due", req_ready, 0);
        wait_until(3132);
        chk(req_ready == 1'b0, "R7", "ready inside refresh cycle", req_ready, 0);
        wait_until(3133);
        chk(req_ready == 1'b1, "R7", "ready after refresh cycle", req_ready, 1);
        expect_cmd(C_REF, 3000, 3121, "R7", i);
    endtask

    task automatic t_refresh_priority;
        int acc, i;
        wait_until(6240);
        chk(req_ready == 1'b0, "R7", "ready with refresh pending", req_ready, 0);
        do_req(1'b0, A1, 32'h0, 4'h0, acc);
        chk(acc == 6254, "R7", "request after refresh", acc, 6254);
        wait_until(acc + 20);
        expect_cmd(C_REF, 6200, 6241, "R7", i);
        expect_cmd(C_ACT, 6241, 6254, "R7", i);
        expect_rv(acc, acc + 4 + CL + 1, 32'h11BB_33DD);
    endtask

    task automatic t_refresh_defer;
        int acc, i;
        wait_until(9357);
        chk(req_ready == 1'b1, "R4", "idle before deferred refresh", req_ready, 1);
        do_req(1'b0, A3, 32'h0, 4'h0, acc);
        chk(acc == 9358, "R4", "accept edge", acc, 9358);
        wait_until(acc + 25);
        expect_cmd(C_REF, acc, 9371, "R7", i);
        expect_rv(acc, acc + 4 + CL + 1, 32'h5555_0002);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_powerup();
        t_write_full();
        t_read_back(32'h1122_3344);
        t_mask();
        t_read_back(32'h11BB_33DD);
        t_back_to_back();
        t_refresh_idle();
        t_refresh_priority();
        t_refresh_defer();
        chk(bad_oe == 0, "R8", "drive or mask outside write", bad_oe, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule